// File: doc/BRIEF.md
# Block-Mode DMA Transfer Sequencer

This block moves a run of words between a local agent and memory once it has won the shared bus. A job gives a starting word address, a word count and a direction: a read from memory (block data in) or a write to memory (block data out). For each bus tenure the sequencer asks for the bus with a request/grant handshake. Once it holds the bus it drives one address beat. It then streams data beats for consecutive addresses and does not send the address again. Every beat waits for a memory acknowledge, so the memory can insert wait states.

The number of words in one tenure is limited. When the option to watch other masters is off, a tenure carries at most 8 words. When the option is on, the block samples the other masters' shared request line as the seventh word is accepted. If no other master is requesting, the tenure may run to 16 words. If one is requesting, the block finishes the eighth word and then gives up the bus. At the start of each tenure the memory reports whether it supports block transfers. If it does not, the tenure carries one address and one data word, which is the single-cycle pattern. After each tenure the block releases the bus for at least one cycle and asks again, until the count is used up. It then pulses `done`.

Top module: `blockDmaSeq`

## Requirements
- R1: After reset, `busReq`, `busOwn`, `addrPhase`, `dataPhase`, `busy` and `done` are all 0.
- R2: A `startValid` pulse in idle with a count of 1 or more raises `busReq` and `busy` in the next cycle. `busOwn` stays 0 until `busGrant` is seen.
- R3: Every tenure begins with exactly one address beat. In that beat `addrPhase` is 1 and `busAddr` carries the address of the next word to move. Data beats follow the address beat and carry no new address.
- R4: Accepted data words carry the addresses start, start+1, start+2, and so on across all tenures, and `wordAddr` gives the address of the current word.
- R5: With `watchReq`=0 and a block-capable memory, no tenure carries more than 8 words. Every tenure except the last carries exactly 8.
- R6: With `watchReq`=1, `otherReq`=0 when the seventh word is accepted, and a block-capable memory, tenures carry 16 words until the remainder is smaller.
- R7: With `watchReq`=1 and `otherReq`=1 when the seventh word is accepted, the tenure ends after its eighth word.
- R8: If `blockCapable` is 0 on the cycle the grant is taken, that tenure carries one word.
- R9: Between two tenures `busOwn` is 0 for at least one cycle, and the block asks for the bus again until every word has moved.
- R10: `done` is a one-cycle pulse. It comes the cycle after the last word is accepted, once exactly `startCount` words have moved. `busy` is 0 in the following cycle.
- R11: A write job (`startWrite`=1) marks each accepted data beat with `wrTake`. A read job (`startWrite`=0) marks it with `rdTake`. The two are never 1 together.
- R12: A start with `startCount`=0 produces `done` in the next cycle with no bus request.
- R13: A `startValid` pulse while `busy`=1 is ignored. The running job keeps its addresses and count.
- R14: While `memAck` is 0, the current beat holds, and the address beat keeps `busAddr` steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Job start pulse, taken only when idle |
| startAddr | input | AW | First word address |
| startCount | input | CW | Number of words to move |
| startWrite | input | 1 | 1 = write to memory, 0 = read from memory |
| watchReq | input | 1 | Enables sampling of other masters' request for 16-word tenures |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| blockCapable | input | 1 | Memory supports block transfers, sampled at grant |
| otherReq | input | 1 | Shared request line of other masters |
| busOwn | output | 1 | Block holds the bus |
| addrPhase | output | 1 | Address beat in progress |
| busAddr | output | AW | Address driven in the address beat, 0 otherwise |
| dataPhase | output | 1 | Data beat in progress |
| memAck | input | 1 | Memory completes the current beat |
| wordAddr | output | AW | Address of the current data word |
| wrTake | output | 1 | Write word accepted this cycle |
| rdTake | output | 1 | Read word accepted this cycle |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job complete pulse |

## Verification
The bound checker watches properties that must hold on every cycle:
- `wrTake` and `rdTake` never rise together.
- Every ownership begins with an address beat.
- A stalled address beat keeps its address.
- The word address steps by one per accepted beat.
- The word count per tenure stays under the 8, 16 and 1 limits for the options in force.
- `done` comes with the bus released.

Other behaviours need whole jobs and can only be shown by the bench's scenarios:
- the exact split into tenures for each combination of watch option, competing request and memory capability;
- the full address sequence against a scoreboard;
- the ignored restart;
- the zero-count job.

// File: rtl/blockDmaSeqPkg.sv
package blockDmaSeqPkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ARB,
    SEQ_ADDR,
    SEQ_DATA,
    SEQ_GAP,
    SEQ_FIN
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // take a new job's address and count
    logic newTenure;  // clear the per-tenure word counter
    logic step;       // one data word accepted
  } pathCtl_t;

endpackage

// File: rtl/blockDmaPath.sv
module blockDmaPath
  import blockDmaSeqPkg::*;
#(
  parameter int unsigned AW = 22,
  parameter int unsigned CW = 16,
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  pathCtl_t      ctl,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] startCount,
  output logic [AW-1:0] curAddr,
  output logic          remOne,
  output logic [TW-1:0] tenWords
);

  logic [CW-1:0] remCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remCnt  <= '0;
    end else if (ctl.load) begin
      curAddr <= startAddr;
      remCnt  <= startCount;
    end else if (ctl.step) begin
      curAddr <= curAddr + AW'(1);
      remCnt  <= remCnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              tenWords <= '0;
    else if (ctl.newTenure) tenWords <= '0;
    else if (ctl.step)      tenWords <= tenWords + TW'(1);
  end

  assign remOne = (remCnt == CW'(1));

endmodule

// File: rtl/blockDmaCtrl.sv
module blockDmaCtrl
  import blockDmaSeqPkg::*;
#(
  parameter int unsigned TW       = 5,
  parameter int unsigned BASE_RUN = 8,
  parameter int unsigned EXT_RUN  = 16,
  parameter int unsigned PROBE_AT = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic          countZero,
  input  logic          startWrite,
  input  logic          watchReq,
  input  logic          busGrant,
  input  logic          blockCapable,
  input  logic          otherReq,
  input  logic          memAck,
  input  logic          remOne,
  input  logic [TW-1:0] tenWords,
  output pathCtl_t      ctl,
  output logic          busReq,
  output logic          busOwn,
  output logic          addrPhase,
  output logic          dataPhase,
  output logic          dirWrite,
  output logic          busy,
  output logic          done
);

  seqState_t state, nxtState;
  logic watchLat, capLat, stopSeen;
  logic [TW-1:0] nWords;
  logic endTenure;

  assign nWords = tenWords + TW'(1);

  assign endTenure = !capLat
                   || (nWords == TW'(EXT_RUN))
                   || ((nWords == TW'(BASE_RUN)) && (!watchLat || stopSeen));

  always_comb begin
    nxtState = state;
    ctl      = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (startValid) begin
          if (countZero) nxtState = SEQ_FIN;
          else begin
            ctl.load = 1'b1;
            nxtState = SEQ_ARB;
          end
        end
      end
      SEQ_ARB: begin
        if (busGrant) begin
          ctl.newTenure = 1'b1;
          nxtState      = SEQ_ADDR;
        end
      end
      SEQ_ADDR: if (memAck) nxtState = SEQ_DATA;
      SEQ_DATA: begin
        if (memAck) begin
          ctl.step = 1'b1;
          if (remOne)         nxtState = SEQ_FIN;
          else if (endTenure) nxtState = SEQ_GAP;
        end
      end
      SEQ_GAP:  nxtState = SEQ_ARB;
      SEQ_FIN:  nxtState = SEQ_IDLE;
      default:  nxtState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nxtState;
  end

  // Job options, held for the whole job
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirWrite <= 1'b0;
      watchLat <= 1'b0;
    end else if (ctl.load) begin
      dirWrite <= startWrite;
      watchLat <= watchReq;
    end
  end

  // Per-tenure memory capability and probe of competing requests
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capLat   <= 1'b0;
      stopSeen <= 1'b0;
    end else if (ctl.newTenure) begin
      capLat   <= blockCapable;
      stopSeen <= 1'b0;
    end else if (ctl.step && watchLat && (nWords == TW'(PROBE_AT))) begin
      stopSeen <= otherReq;
    end
  end

  assign busReq    = (state == SEQ_ARB);
  assign addrPhase = (state == SEQ_ADDR);
  assign dataPhase = (state == SEQ_DATA);
  assign busOwn    = addrPhase || dataPhase;
  assign busy      = (state != SEQ_IDLE);
  assign done      = (state == SEQ_FIN);

endmodule

// File: rtl/blockDmaSeq.sv
module blockDmaSeq
  import blockDmaSeqPkg::*;
#(
  parameter int unsigned AW       = 22,
  parameter int unsigned CW       = 16,
  parameter int unsigned BASE_RUN = 8,
  parameter int unsigned EXT_RUN  = 16,
  parameter int unsigned PROBE_AT = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] startCount,
  input  logic          startWrite,
  input  logic          watchReq,
  output logic          busReq,
  input  logic          busGrant,
  input  logic          blockCapable,
  input  logic          otherReq,
  output logic          busOwn,
  output logic          addrPhase,
  output logic [AW-1:0] busAddr,
  output logic          dataPhase,
  input  logic          memAck,
  output logic [AW-1:0] wordAddr,
  output logic          wrTake,
  output logic          rdTake,
  output logic          busy,
  output logic          done
);

  localparam int unsigned TW = $clog2(EXT_RUN + 1);

  pathCtl_t      ctl;
  logic          remOne;
  logic [TW-1:0] tenWords;
  logic [AW-1:0] curAddr;
  logic          dirWrite;
  logic          countZero;

  assign countZero = (startCount == '0);

  blockDmaCtrl #(
    .TW(TW), .BASE_RUN(BASE_RUN), .EXT_RUN(EXT_RUN), .PROBE_AT(PROBE_AT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .countZero(countZero),
    .startWrite(startWrite), .watchReq(watchReq), .busGrant(busGrant),
    .blockCapable(blockCapable), .otherReq(otherReq), .memAck(memAck),
    .remOne(remOne), .tenWords(tenWords), .ctl(ctl), .busReq(busReq),
    .busOwn(busOwn), .addrPhase(addrPhase), .dataPhase(dataPhase),
    .dirWrite(dirWrite), .busy(busy), .done(done)
  );

  blockDmaPath #(.AW(AW), .CW(CW), .TW(TW)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .startCount(startCount), .curAddr(curAddr), .remOne(remOne),
    .tenWords(tenWords)
  );

  assign busAddr  = addrPhase ? curAddr : '0;
  assign wordAddr = curAddr;
  assign wrTake   = dataPhase && memAck && dirWrite;
  assign rdTake   = dataPhase && memAck && !dirWrite;

endmodule

// File: rtl/blockDmaSeqChk.sv
module blockDmaSeqChk #(
  parameter int unsigned AW       = 22,
  parameter int unsigned BASE_RUN = 8,
  parameter int unsigned EXT_RUN  = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          startValid,
  input logic          watchReq,
  input logic          busReq,
  input logic          busGrant,
  input logic          blockCapable,
  input logic          busOwn,
  input logic          addrPhase,
  input logic [AW-1:0] busAddr,
  input logic          dataPhase,
  input logic          memAck,
  input logic [AW-1:0] wordAddr,
  input logic          wrTake,
  input logic          rdTake,
  input logic          busy,
  input logic          done
);

  logic [7:0] tenBeats;
  logic watchSeen, capSeen;

  always_ff @(posedge clk) begin
    if (!rstN)                  tenBeats <= '0;
    else if (!busOwn)           tenBeats <= '0;
    else if (dataPhase && memAck && tenBeats != 8'hFF) tenBeats <= tenBeats + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      watchSeen <= 1'b1;
      capSeen   <= 1'b1;
    end else begin
      if (startValid && !busy) watchSeen <= watchReq;
      if (busReq && busGrant)  capSeen   <= blockCapable;
    end
  end

  // R11
  take_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrTake && rdTake));

  // R3
  own_starts_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOwn) |-> addrPhase);

  // R3
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase && memAck) |=> dataPhase);

  // R14
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase && !memAck) |=> (addrPhase && $stable(busAddr)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && memAck) |=> (wordAddr == AW'($past(wordAddr) + 1)));

  // R5
  base_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !watchSeen |-> (tenBeats <= 8'(BASE_RUN)));

  // R6
  ext_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tenBeats <= 8'(EXT_RUN));

  // R8
  single_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capSeen |-> (tenBeats <= 8'd1));

  // R9
  gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOwn) |=> !busOwn);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busOwn && !busReq));

endmodule

bind blockDmaSeq blockDmaSeqChk #(
  .AW(AW), .BASE_RUN(BASE_RUN), .EXT_RUN(EXT_RUN)
) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .watchReq(watchReq),
  .busReq(busReq), .busGrant(busGrant), .blockCapable(blockCapable),
  .busOwn(busOwn), .addrPhase(addrPhase), .busAddr(busAddr),
  .dataPhase(dataPhase), .memAck(memAck), .wordAddr(wordAddr),
  .wrTake(wrTake), .rdTake(rdTake), .busy(busy), .done(done)
);

// File: tb/blockDmaSeq_tb.sv
module blockDmaSeq_tb;

  localparam int AW = 22;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [CW-1:0] startCount = '0;
  logic startWrite = 1'b0;
  logic watchReq = 1'b0;
  logic busReq, busOwn, addrPhase, dataPhase, wrTake, rdTake, busy, done;
  logic busGrant = 1'b0;
  logic blockCapable = 1'b1;
  logic otherReq = 1'b0;
  logic memAck = 1'b1;
  logic [AW-1:0] busAddr, wordAddr;

  always #4 clk = ~clk;

  blockDmaSeq u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .startCount(startCount), .startWrite(startWrite), .watchReq(watchReq),
    .busReq(busReq), .busGrant(busGrant), .blockCapable(blockCapable),
    .otherReq(otherReq), .busOwn(busOwn), .addrPhase(addrPhase),
    .busAddr(busAddr), .dataPhase(dataPhase), .memAck(memAck),
    .wordAddr(wordAddr), .wrTake(wrTake), .rdTake(rdTake), .busy(busy),
    .done(done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Stall pattern source and bench arbiter
  logic [7:0] lfsr = 8'h5A;
  bit stallOn = 1'b0;
  always @(posedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memAck   <= stallOn ? (lfsr[1] | lfsr[3]) : 1'b1;
    busGrant <= busReq && !busGrant && lfsr[2];
  end

  // Scoreboard
  int    expAddr[$];
  int    expLen[$];
  bit    jobWrite;
  string lenTag = "R5";
  int    curLen = 0;
  int    addrBeats = 0;
  int    tenures = 0;
  bit    prevOwn = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busOwn && !prevOwn) begin
        check(addrPhase, "R3 tenure opens with address beat", addrPhase, 1);
        if (expAddr.size() > 0)
          check(busAddr == AW'(expAddr[0]), "R3 address beat value", busAddr, expAddr[0]);
      end
      if (addrPhase && memAck) addrBeats++;
      if (wrTake || rdTake) begin
        int e;
        e = (expAddr.size() > 0) ? expAddr.pop_front() : -1;
        check(wordAddr == AW'(e), "R4 word address", wordAddr, e);
        check(wrTake == jobWrite, "R11 direction strobe", wrTake, jobWrite);
        curLen++;
      end
      if (!busOwn && prevOwn) begin
        int l;
        l = (expLen.size() > 0) ? expLen.pop_front() : -1;
        check(curLen == l, {lenTag, " tenure length"}, curLen, l);
        check(addrBeats == 1, "R3 one address beat per tenure", addrBeats, 1);
        curLen = 0;
        addrBeats = 0;
        tenures++;
      end
      prevOwn = busOwn;
    end
  end

  task automatic runJob(input int addr, input int cnt, input bit wr, input bit watch,
                        input bit cap, input bit other, input string tag, input bit poke);
    int maxRun, rem, nTen, t0;
    @(negedge clk);
    startAddr = AW'(addr); startCount = CW'(cnt); startWrite = wr;
    watchReq = watch; blockCapable = cap; otherReq = other;
    jobWrite = wr; lenTag = tag;
    for (int i = 0; i < cnt; i++) expAddr.push_back(addr + i);
    maxRun = !cap ? 1 : ((!watch || other) ? 8 : 16);
    rem = cnt; nTen = 0;
    while (rem > 0) begin
      expLen.push_back(rem < maxRun ? rem : maxRun);
      rem -= (rem < maxRun ? rem : maxRun);
      nTen++;
    end
    t0 = tenures;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    check(busReq && busy, "R2 request after start", busReq, 1);
    check(!busOwn, "R2 no ownership before grant", busOwn, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      startAddr = AW'(addr + 'h100); startCount = CW'(3);
      startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
    end
    while (!done) @(negedge clk);
    check(expAddr.size() == 0, "R10 all words moved at done", expAddr.size(), 0);
    @(negedge clk);
    check(!busy && !done, "R10 idle after done pulse", busy, 0);
    check(tenures - t0 == nTen, poke ? "R13 tenure count unchanged by restart"
                                     : "R9 tenure count", tenures - t0, nTen);
    expAddr.delete();
    expLen.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busReq && !busOwn && !addrPhase && !dataPhase && !busy && !done,
          "R1 reset state", {busReq, busOwn, busy, done}, 0);

    runJob('h1000, 1,  1'b1, 1'b0, 1'b1, 1'b0, "R3", 1'b0);
    runJob('h2000, 20, 1'b0, 1'b0, 1'b1, 1'b1, "R5", 1'b0);
    runJob('h3000, 40, 1'b1, 1'b1, 1'b1, 1'b0, "R6", 1'b0);
    runJob('h4000, 20, 1'b0, 1'b1, 1'b1, 1'b1, "R7", 1'b0);
    runJob('h5000, 3,  1'b1, 1'b1, 1'b0, 1'b0, "R8", 1'b0);
    stallOn = 1'b1;
    runJob('h6000, 16, 1'b0, 1'b1, 1'b1, 1'b0, "R14", 1'b0);
    runJob('h3FFFF0, 10, 1'b1, 1'b0, 1'b1, 1'b0, "R13", 1'b1);
    stallOn = 1'b0;

    // R12 zero-length job
    @(negedge clk);
    startCount = '0;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    check(done && !busReq, "R12 zero count done without request", done, 1);
    @(negedge clk);
    check(!busy && !busOwn, "R12 idle after zero count", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule